// File: doc/BRIEF.md
# Legacy Decode Group Allocator

The block stands in the instruction front end at the point where the legacy decoders work. Each cycle it looks at a window of up to eight instructions that have already been length-decoded. Each instruction arrives as an optional REX byte, an opcode byte and a ModRM byte. For each instruction the block decides whether one of the simple decoders can take it or whether only the complex decoder can. It then picks how many instructions from the head of the window form this cycle's decode group. It places each of them in a decoder slot and reports how many µops each one emits.

Which decoder may take an instruction is decided from the opcode byte alone, and the REX prefix plays no part in it. The one-byte pop whose low register bits are 100 is therefore always sent to the complex decoder, whether it names the stack pointer or r12. The two-byte ModRM form of the same pop still goes to a simple decoder. A one-bit input selects between two rule sets. Under the older rule set, that pop must decode with nothing else in its cycle. Under the newer rule set, a complex-only instruction may share its cycle with up to three simple ones.

The caller keeps every instruction that was not consumed at the head of the window for the next cycle. The results are registered, so they appear one cycle after the window is presented.

Top module: `ldg_top`

## Requirements
- R1: Opcode 0x5C is complex-only whether or not REX.B (bit 0 of the REX byte, present when the has-REX flag is set and the byte's upper nibble is 0100) is set. The other short-form pops 0x58–0x5F are simple.
- R2: Opcode 0x5C emits 3 µops without REX.B and 1 µop with REX.B. The other short-form pops emit 1 µop.
- R3: Opcode 0x8F with ModRM reg field (bits 5:3) equal to 0 and a register destination (mod, bits 7:6, equal to 11) is simple and emits 1 µop. The same form with a memory destination (mod not 11) is complex-only and emits 2 µops.
- R4: Pushes 0x50–0x57, including 0x54 with or without REX.B, are simple and emit 1 µop. Any opcode not covered by R1–R3 is simple and emits 1 µop.
- R5: A group holds at most four instructions. The consumed count equals the number of set slot-valid bits, and those bits fill from slot 0 without gaps.
- R6: A complex-only instruction may occupy only slot 0. A complex-only instruction at a later window position ends the group just before it.
- R7: With core_new = 0, an instruction with opcode 0x5C in slot 0 forms a group of one. Other complex-only instructions may still take up to three following simple ones.
- R8: With core_new = 1, a complex-only instruction in slot 0 is followed in the same group by up to three simple instructions.
- R9: An entry whose valid bit is clear ends the group. A window whose first entry is invalid gives a consumed count of 0 and no valid slots.
- R10: All outputs are registered and show the result for the window presented before the latest clock edge. During reset they are zero, and slots that are not valid report zero for the complex flag and the µop count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_new | input | 1 | 1 selects the newer grouping rules, 0 the older |
| ent_valid | input | 8 | Window entry valid, bit i for entry i (entry 0 is the head) |
| ent_has_rex | input | 8 | Entry i carries a REX byte |
| ent_rex | input | 64 | REX byte of entry i at bits 8i+7:8i |
| ent_opcode | input | 64 | Opcode byte of entry i at bits 8i+7:8i |
| ent_modrm | input | 64 | ModRM byte of entry i at bits 8i+7:8i |
| take_count | output | 3 | Number of head entries consumed this cycle, 0 to 4 |
| slot_valid | output | 4 | Slot i holds window entry i |
| slot_complex | output | 4 | Slot i holds a complex-only instruction |
| slot_uops | output | 8 | µop count of slot i at bits 2i+1:2i |

## Verification
Two things can land in the same cycle: the complex-only pop at the head of the window, and the group cut that the following simple instructions run into. The newer rules let them share a group, while the older rules isolate the pop. The bench provokes this by replaying streams of one pop variant followed by zero to seven nops under both rule sets. Each run is judged by the number of cycles it takes to drain the stream, and that number is compared with a count derived arithmetically from the group rules. Single-window probes check the classification, the µop counts and the point at which a group is cut.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

    localparam int UOP_W = 2;

    localparam logic [7:0] OPC_POP_BASE  = 8'h58;
    localparam logic [7:0] OPC_POP_SP    = 8'h5C;
    localparam logic [7:0] OPC_POP_MODRM = 8'h8F;
    localparam logic [3:0] REX_NIBBLE    = 4'b0100;

    typedef struct packed {
        logic             cplx;
        logic             solo;
        logic [UOP_W-1:0] uops;
    } ins_class_t;

endpackage

// File: rtl/ldg_classify.sv
module ldg_classify
    import ldg_pkg::*;
(
    input  logic       has_rex,
    input  logic [7:0] rex,
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output ins_class_t cls
);

    logic rex_b;
    logic unused_bits;

    assign rex_b       = has_rex && (rex[7:4] == REX_NIBBLE) && rex[0];
    assign unused_bits = ^{rex[3:1], modrm[2:0]};

    always_comb begin
        cls      = '0;
        cls.uops = UOP_W'(1);
        if (opcode == OPC_POP_SP) begin
            // eligibility from the opcode byte only; REX only changes the uop count
            cls.cplx = 1'b1;
            cls.solo = 1'b1;
            cls.uops = rex_b ? UOP_W'(1) : UOP_W'(3);
        end else if (opcode == OPC_POP_MODRM && modrm[5:3] == 3'd0
                     && modrm[7:6] != 2'b11) begin
            cls.cplx = 1'b1;
            cls.uops = UOP_W'(2);
        end
    end

endmodule

// File: rtl/ldg_grouper.sv
module ldg_grouper
    import ldg_pkg::*;
#(
    parameter int WIN   = 8,
    parameter int GROUP = 4,
    localparam int TAKE_W = $clog2(GROUP + 1)
) (
    input  logic                   core_new,
    input  logic [WIN-1:0]         valid,
    input  ins_class_t [WIN-1:0]   cls,
    output logic [TAKE_W-1:0]      take,
    output logic [GROUP-1:0]       s_vld,
    output logic [GROUP-1:0]       s_cplx,
    output logic [GROUP*UOP_W-1:0] s_uops
);

    always_comb begin
        logic stop;
        logic ok;
        stop   = 1'b0;
        take   = '0;
        s_vld  = '0;
        s_cplx = '0;
        s_uops = '0;
        for (int i = 0; i < GROUP; i++) begin
            ok = !stop && valid[i];
            if (ok && i > 0 && cls[i].cplx) ok = 1'b0;
            if (ok && i > 0 && !core_new && cls[0].solo) ok = 1'b0;
            if (ok) begin
                s_vld[i]                = 1'b1;
                s_cplx[i]               = cls[i].cplx;
                s_uops[i*UOP_W +: UOP_W] = cls[i].uops;
                take                    = take + TAKE_W'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ldg_top.sv
module ldg_top
    import ldg_pkg::*;
#(
    parameter int WIN   = 8,
    parameter int GROUP = 4,
    localparam int TAKE_W = $clog2(GROUP + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    core_new,
    input  logic [WIN-1:0]          ent_valid,
    input  logic [WIN-1:0]          ent_has_rex,
    input  logic [WIN*8-1:0]        ent_rex,
    input  logic [WIN*8-1:0]        ent_opcode,
    input  logic [WIN*8-1:0]        ent_modrm,
    output logic [TAKE_W-1:0]       take_count,
    output logic [GROUP-1:0]        slot_valid,
    output logic [GROUP-1:0]        slot_complex,
    output logic [GROUP*UOP_W-1:0]  slot_uops
);

    typedef struct packed {
        logic [TAKE_W-1:0]      take;
        logic [GROUP-1:0]       vld;
        logic [GROUP-1:0]       cplx;
        logic [GROUP*UOP_W-1:0] uops;
    } out_t;

    ins_class_t [WIN-1:0]   cls;
    logic [TAKE_W-1:0]      g_take;
    logic [GROUP-1:0]       g_vld;
    logic [GROUP-1:0]       g_cplx;
    logic [GROUP*UOP_W-1:0] g_uops;
    out_t                   out_d, out_q;

    for (genvar i = 0; i < WIN; i++) begin : g_cls
        ldg_classify u_cls (
            .has_rex (ent_has_rex[i]),
            .rex     (ent_rex[i*8 +: 8]),
            .opcode  (ent_opcode[i*8 +: 8]),
            .modrm   (ent_modrm[i*8 +: 8]),
            .cls     (cls[i])
        );
    end

    ldg_grouper #(.WIN(WIN), .GROUP(GROUP)) u_grp (
        .core_new (core_new),
        .valid    (ent_valid),
        .cls      (cls),
        .take     (g_take),
        .s_vld    (g_vld),
        .s_cplx   (g_cplx),
        .s_uops   (g_uops)
    );

    always_comb begin
        out_d      = out_q;
        out_d.take = g_take;
        out_d.vld  = g_vld;
        out_d.cplx = g_cplx;
        out_d.uops = g_uops;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign take_count   = out_q.take;
    assign slot_valid   = out_q.vld;
    assign slot_complex = out_q.cplx;
    assign slot_uops    = out_q.uops;

endmodule

// File: rtl/ldg_chk.sv
module ldg_chk #(
    parameter int WIN   = 8,
    parameter int GROUP = 4,
    localparam int TAKE_W = $clog2(GROUP + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   core_new,
    input logic [WIN-1:0]         ent_valid,
    input logic [WIN-1:0]         ent_has_rex,
    input logic [WIN*8-1:0]       ent_rex,
    input logic [WIN*8-1:0]       ent_opcode,
    input logic [WIN*8-1:0]       ent_modrm,
    input logic [TAKE_W-1:0]      take_count,
    input logic [GROUP-1:0]       slot_valid,
    input logic [GROUP-1:0]       slot_complex,
    input logic [GROUP*2-1:0]     slot_uops
);

    logic head_pop_sp;
    logic head_rex_b;
    assign head_pop_sp = ent_valid[0] && ent_opcode[7:0] == 8'h5C;
    assign head_rex_b  = ent_has_rex[0] && ent_rex[7:4] == 4'b0100 && ent_rex[0];

    // R5
    take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_count <= TAKE_W'(GROUP)) && (int'(take_count) == $countones(slot_valid)));

    // R5
    slot_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid & (slot_valid + GROUP'(1))) == '0));

    // R6
    cplx_head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_complex[GROUP-1:1] == '0));

    // R7
    old_pop_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pop_sp && !core_new) |=> (take_count == TAKE_W'(1)));

    // R2
    pop_r12_uop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pop_sp && head_rex_b) |=> (slot_complex[0] && slot_uops[1:0] == 2'd1));

    // R4
    push_simple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid[0] && ent_opcode[7:0] == 8'h54) |=> (!slot_complex[0] && slot_uops[1:0] == 2'd1));

    // R9
    empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ent_valid[0]) |=> (take_count == '0 && slot_valid == '0));

    // R10
    idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_complex & ~slot_valid) == '0));

endmodule

bind ldg_top ldg_chk #(.WIN(WIN), .GROUP(GROUP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_new     (core_new),
    .ent_valid    (ent_valid),
    .ent_has_rex  (ent_has_rex),
    .ent_rex      (ent_rex),
    .ent_opcode   (ent_opcode),
    .ent_modrm    (ent_modrm),
    .take_count   (take_count),
    .slot_valid   (slot_valid),
    .slot_complex (slot_complex),
    .slot_uops    (slot_uops)
);

// File: tb/ldg_top_bench.sv
`timescale 1ns/1ps
module ldg_top_bench;

    localparam int WIN = 8;
    localparam int GROUP = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           core_new = 1'b0;
    logic [WIN-1:0] ent_valid = '0;
    logic [WIN-1:0] ent_has_rex = '0;
    logic [WIN*8-1:0] ent_rex = '0;
    logic [WIN*8-1:0] ent_opcode = '0;
    logic [WIN*8-1:0] ent_modrm = '0;
    logic [2:0]     take_count;
    logic [3:0]     slot_valid;
    logic [3:0]     slot_complex;
    logic [7:0]     slot_uops;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // stream storage
    bit       s_has[16];
    bit [7:0] s_rex[16];
    bit [7:0] s_opc[16];
    bit [7:0] s_mrm[16];
    int       s_len;

    always #5 clk = ~clk;

    ldg_top #(.WIN(WIN), .GROUP(GROUP)) u_ldg_top (
        .clk(clk), .rst_n(rst_n), .core_new(core_new),
        .ent_valid(ent_valid), .ent_has_rex(ent_has_rex), .ent_rex(ent_rex),
        .ent_opcode(ent_opcode), .ent_modrm(ent_modrm),
        .take_count(take_count), .slot_valid(slot_valid),
        .slot_complex(slot_complex), .slot_uops(slot_uops)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_win();
        ent_valid = '0; ent_has_rex = '0; ent_rex = '0; ent_opcode = '0; ent_modrm = '0;
    endtask

    task automatic set_ent(input int i, input bit has, input bit [7:0] rex,
                           input bit [7:0] opc, input bit [7:0] mrm);
        ent_valid[i]         = 1'b1;
        ent_has_rex[i]       = has;
        ent_rex[i*8 +: 8]    = rex;
        ent_opcode[i*8 +: 8] = opc;
        ent_modrm[i*8 +: 8]  = mrm;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // single instruction at the head, check flag and uop count of slot 0
    task automatic probe(input string req, input bit has, input bit [7:0] rex,
                         input bit [7:0] opc, input bit [7:0] mrm,
                         input int exp_cplx, input int exp_uops);
        clear_win();
        set_ent(0, has, rex, opc, mrm);
        step();
        check({req, " complex"}, int'(slot_complex[0]), exp_cplx);
        check({req, " uops"}, int'(slot_uops[1:0]), exp_uops);
    endtask

    task automatic drain(input bit mode, output int cycles);
        int pos;
        pos = 0;
        cycles = 0;
        core_new = mode;
        while (pos < s_len && cycles < 40) begin
            clear_win();
            for (int j = 0; j < WIN; j++)
                if (pos + j < s_len)
                    set_ent(j, s_has[pos+j], s_rex[pos+j], s_opc[pos+j], s_mrm[pos+j]);
            step();
            if (take_count == 0) begin
                cycles = 99;
                break;
            end
            pos += int'(take_count);
            cycles++;
        end
    endtask

    initial begin
        int cyc;
        int exp;
        clear_win();
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 reset take", int'(take_count), 0);
        check("R10 reset slots", int'({slot_valid, slot_complex, slot_uops}), 0);
        rst_n = 1'b1;

        // R1 / R2 classification of short pops
        probe("R1 R2 pop sp", 1'b0, 8'h00, 8'h5C, 8'h00, 1, 3);
        probe("R1 R2 pop r12", 1'b1, 8'h41, 8'h5C, 8'h00, 1, 1);
        probe("R1 pop r11", 1'b1, 8'h41, 8'h5B, 8'h00, 0, 1);
        probe("R1 pop rax", 1'b0, 8'h00, 8'h58, 8'h00, 0, 1);
        // R3 modrm pop forms
        probe("R3 pop r12 modrm", 1'b1, 8'h41, 8'h8F, 8'hC4, 0, 1);
        probe("R3 pop mem", 1'b0, 8'h00, 8'h8F, 8'h04, 1, 2);
        // R4 push and default
        probe("R4 push sp", 1'b0, 8'h00, 8'h54, 8'h00, 0, 1);
        probe("R4 push r12", 1'b1, 8'h41, 8'h54, 8'h00, 0, 1);
        probe("R4 nop", 1'b0, 8'h00, 8'h90, 8'h00, 0, 1);

        // R5 full window of nops
        core_new = 1'b1;
        clear_win();
        for (int j = 0; j < WIN; j++) set_ent(j, 1'b0, 8'h00, 8'h90, 8'h00);
        step();
        check("R5 take of eight nops", int'(take_count), 4);
        check("R5 slot_valid", int'(slot_valid), 15);

        // R10 output holds until the next edge
        clear_win();
        #2;
        check("R10 hold before edge", int'(take_count), 4);

        // R9 invalid entries
        step();
        check("R9 empty window take", int'(take_count), 0);
        check("R9 empty window slots", int'(slot_valid), 0);
        clear_win();
        set_ent(0, 1'b0, 8'h00, 8'h90, 8'h00);
        set_ent(1, 1'b0, 8'h00, 8'h90, 8'h00);
        set_ent(3, 1'b0, 8'h00, 8'h90, 8'h00);
        step();
        check("R9 gap ends group", int'(take_count), 2);

        // R6 complex at later position
        clear_win();
        set_ent(0, 1'b0, 8'h00, 8'h90, 8'h00);
        set_ent(1, 1'b0, 8'h00, 8'h90, 8'h00);
        set_ent(2, 1'b1, 8'h41, 8'h5C, 8'h00);
        set_ent(3, 1'b0, 8'h00, 8'h90, 8'h00);
        step();
        check("R6 cut before complex", int'(take_count), 2);
        check("R6 no complex slot", int'(slot_complex), 0);

        // R7 older mode: memory pop (complex, not 0x5C) still shares
        core_new = 1'b0;
        clear_win();
        set_ent(0, 1'b0, 8'h00, 8'h8F, 8'h04);
        for (int j = 1; j < 5; j++) set_ent(j, 1'b0, 8'h00, 8'h90, 8'h00);
        step();
        check("R7 older mode memory pop shares", int'(take_count), 4);
        // R8 newer mode: pop r12 with three nops
        core_new = 1'b1;
        clear_win();
        set_ent(0, 1'b1, 8'h41, 8'h5C, 8'h00);
        for (int j = 1; j < 5; j++) set_ent(j, 1'b0, 8'h00, 8'h90, 8'h00);
        step();
        check("R8 newer mode pop plus three", int'(take_count), 4);
        check("R8 pop in slot 0 complex", int'(slot_complex), 1);

        // R7 R8 sweep: head variant, 0..7 nops, both modes
        for (int kind = 0; kind < 4; kind++) begin
            for (int k = 0; k < 8; k++) begin
                for (int m = 0; m < 2; m++) begin
                    s_len = k + 1;
                    case (kind)
                        0: begin s_has[0] = 0; s_rex[0] = 8'h00; s_opc[0] = 8'h5C; s_mrm[0] = 8'h00; end
                        1: begin s_has[0] = 1; s_rex[0] = 8'h41; s_opc[0] = 8'h5C; s_mrm[0] = 8'h00; end
                        2: begin s_has[0] = 1; s_rex[0] = 8'h41; s_opc[0] = 8'h8F; s_mrm[0] = 8'hC4; end
                        default: begin s_has[0] = 1; s_rex[0] = 8'h41; s_opc[0] = 8'h5B; s_mrm[0] = 8'h00; end
                    endcase
                    for (int j = 1; j <= k; j++) begin
                        s_has[j] = 0; s_rex[j] = 8'h00; s_opc[j] = 8'h90; s_mrm[j] = 8'h00;
                    end
                    if (kind < 2 && m == 0) exp = 1 + (k + 3) / 4;
                    else                    exp = (k + 1 + 3) / 4;
                    drain(m[0], cyc);
                    check($sformatf("%s kind%0d nops%0d", (m == 0) ? "R7" : "R8", kind, k), cyc, exp);
                end
            end
        end

        // R5 twelve nops drain in three cycles
        s_len = 12;
        for (int j = 0; j < 12; j++) begin
            s_has[j] = 0; s_rex[j] = 8'h00; s_opc[j] = 8'h90; s_mrm[j] = 8'h00;
        end
        drain(1'b0, cyc);
        check("R5 twelve nops", cyc, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule